// File: doc/BRIEF.md
# Exception Vector Fetch Unit with Security Attribution

During exception entry this block reads the handler address from the vector table. The core supplies an exception number and the security state the exception targets. The block picks the secure or the non-secure vector base according to that state and adds four times the exception number to form the table address. When the security extension is built in (`SEC_EXT=1`), it looks the address up in a four-region attribution table. It then issues one privileged word read on a simple valid/ready bus that has an error response.

Vector reads use the default memory map, so no protection-unit check takes part. The attribution result alone decides whether the read goes out as secure or non-secure, or whether the fetch is refused. A refused fetch and a bus error are both fetch failures. On a failure the block sets two sticky HardFault status bits. It also raises a pending derived HardFault whose security target follows the original target and the "faults may go non-secure" control bit. The core then restarts entry as a tail-chain, so the HardFault is taken next. If the exception that failed is HardFault itself, the block raises a sticky lockup flag instead. When the extension is absent (`SEC_EXT=0`), the read carries the target state as its secure attribute.

Top module: `excvec_fetch`

## Requirements
- R1: The bus read address equals `vbase_s` when `tgt_secure`=1, or `vbase_ns` when `tgt_secure`=0, plus 4 × `exc_num`, with modulo 2^32 wrap.
- R2: Every bus request has `bus_priv`=1.
- R3: An address is non-secure only when exactly one enabled region covers it and that region has its NSC flag at 0. A region covers the address when `base` ≤ addr[31:5] ≤ `limit`. No hit, a disabled region, an NSC hit and an overlap of two hits all make the address secure. A non-secure address is read with `bus_secure`=0.
- R4: A secure address with `tgt_secure`=0 fails without any bus request, and a request is never issued secure for a non-secure target.
- R5: A secure address with `tgt_secure`=1 is read with `bus_secure`=1.
- R6: A response with `bus_rsp_err`=1 makes the fetch fail.
- R7: Every fetch ends with exactly one `done` pulse lasting one cycle. On success `fail`=0, `vector` holds the returned data and no HardFault is pended. `fail` is only ever high together with `done`.
- R8: A failure sets `hfsr_vecttbl` and `hfsr_forced`, which stay at 1 until reset. A successful fetch leaves them unchanged.
- R9: When a failed exception is not number 3, `hf_pend` pulses with `done`. `hf_pend_secure` = `tgt_secure` OR NOT `faults_ns`, using the values sampled at `start`.
- R10: A failure while entering exception 3 (HardFault) sets `lockup`, which stays at 1 until reset, and does not pulse `hf_pend`.
- R11: A request is held, with address and attributes unchanged, until `bus_req_ready`. Only one request is ever outstanding.
- R12: After reset `done`, `fail`, `bus_req_valid`, `hf_pend`, `lockup`, `hfsr_vecttbl` and `hfsr_forced` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch (accepted only while idle) |
| exc_num | input | EXC_W | Exception number |
| tgt_secure | input | 1 | Exception targets the secure state |
| faults_ns | input | 1 | Control bit allowing faults to target non-secure |
| vbase_s | input | 32 | Secure vector base |
| vbase_ns | input | 32 | Non-secure vector base |
| sau_en | input | NREG | Region enable bits |
| sau_nsc | input | NREG | Region NSC flags |
| sau_base | input | NREG×27 | Region base, address bits [31:5] |
| sau_limit | input | NREG×27 | Region limit, address bits [31:5], inclusive |
| done | output | 1 | Fetch complete (one-cycle pulse) |
| fail | output | 1 | Fetch failed (with done) |
| vector | output | 32 | Fetched vector (valid with done and !fail) |
| hfsr_vecttbl | output | 1 | Sticky vector-table fault status bit |
| hfsr_forced | output | 1 | Sticky forced fault status bit |
| hf_pend | output | 1 | Pend derived HardFault (pulse) |
| hf_pend_secure | output | 1 | Security target of the derived HardFault |
| lockup | output | 1 | Sticky lockup flag |
| bus_req_valid | output | 1 | Read request valid |
| bus_req_ready | input | 1 | Read request accepted |
| bus_addr | output | 32 | Read address |
| bus_secure | output | 1 | Secure attribute of the read |
| bus_priv | output | 1 | Privileged attribute of the read |
| bus_rsp_valid | input | 1 | Read response valid |
| bus_rsp_data | input | 32 | Read data |
| bus_rsp_err | input | 1 | Read error |

## Verification
The assertions assume the bus responds only after it has accepted a request, and gives exactly one response per request. They also assume the base registers and region table stay stable while a fetch is in progress. The bench's bus model captures a request, raises ready after a chosen delay of zero to two cycles, and returns one response on the following cycle. It changes configuration only between fetches. `faults_ns` is held steady from `start` until `done`.

// File: rtl/excvec_pkg.sv
package excvec_pkg;
    localparam int ADDR_W   = 32;
    localparam int GRAN_LSB = 5;
    localparam int BLK_W    = ADDR_W - GRAN_LSB;
    localparam int HARDFAULT_NUM = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_OK,
        ST_BAD
    } fetch_st_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              secure;
    } vreq_t;

    function automatic logic [ADDR_W-1:0] vec_addr(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-3:0] idx
    );
        return base + {idx, 2'b00};
    endfunction
endpackage

// File: rtl/excvec_sau.sv
module excvec_sau
    import excvec_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NREG-1:0]             en,
    input  logic [NREG-1:0]             nsc,
    input  logic [NREG-1:0][BLK_W-1:0]  base,
    input  logic [NREG-1:0][BLK_W-1:0]  limit,
    output logic                        is_ns
);
    localparam int CNT_W = $clog2(NREG + 1);

    logic [BLK_W-1:0] blk;
    logic [NREG-1:0]  hit;
    logic [NREG-1:0]  ns_hit;
    logic [CNT_W-1:0] nhits;

    assign blk = addr[ADDR_W-1:GRAN_LSB];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        assign hit[i]    = en[i] && (blk >= base[i]) && (blk <= limit[i]);
        assign ns_hit[i] = hit[i] && !nsc[i];
    end

    always_comb begin
        nhits = '0;
        for (int i = 0; i < NREG; i++) begin
            nhits = nhits + CNT_W'(hit[i]);
        end
    end

    assign is_ns = (nhits == CNT_W'(1)) && (|ns_hit);
endmodule

// File: rtl/excvec_fault.sv
module excvec_fault #(
    parameter int EXC_W = 9,
    parameter int HF_NUM = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fail_evt,
    input  logic [EXC_W-1:0] exc_q,
    input  logic             tgt_q,
    input  logic             fns_q,
    output logic             hfsr_vecttbl,
    output logic             hfsr_forced,
    output logic             hf_pend,
    output logic             hf_pend_secure,
    output logic             lockup
);
    logic is_hf;

    assign is_hf          = (exc_q == EXC_W'(HF_NUM));
    assign hf_pend        = fail_evt && !is_hf;
    assign hf_pend_secure = hf_pend && (tgt_q || !fns_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hfsr_vecttbl <= 1'b0;
            hfsr_forced  <= 1'b0;
            lockup       <= 1'b0;
        end else if (fail_evt) begin
            hfsr_vecttbl <= 1'b1;
            hfsr_forced  <= 1'b1;
            if (is_hf) begin
                lockup <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/excvec_fetch.sv
module excvec_fetch
    import excvec_pkg::*;
#(
    parameter int NREG    = 4,
    parameter int EXC_W   = 9,
    parameter bit SEC_EXT = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [EXC_W-1:0]            exc_num,
    input  logic                        tgt_secure,
    input  logic                        faults_ns,
    input  logic [ADDR_W-1:0]           vbase_s,
    input  logic [ADDR_W-1:0]           vbase_ns,
    input  logic [NREG-1:0]             sau_en,
    input  logic [NREG-1:0]             sau_nsc,
    input  logic [NREG-1:0][BLK_W-1:0]  sau_base,
    input  logic [NREG-1:0][BLK_W-1:0]  sau_limit,
    output logic                        done,
    output logic                        fail,
    output logic [ADDR_W-1:0]           vector,
    output logic                        hfsr_vecttbl,
    output logic                        hfsr_forced,
    output logic                        hf_pend,
    output logic                        hf_pend_secure,
    output logic                        lockup,
    output logic                        bus_req_valid,
    input  logic                        bus_req_ready,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic                        bus_secure,
    output logic                        bus_priv,
    input  logic                        bus_rsp_valid,
    input  logic [ADDR_W-1:0]           bus_rsp_data,
    input  logic                        bus_rsp_err
);
    fetch_st_t         st;
    vreq_t             req_q;
    logic [EXC_W-1:0]  exc_q;
    logic              tgt_q;
    logic              fns_q;
    logic [ADDR_W-1:0] vec_q;
    logic [ADDR_W-1:0] va;
    logic              va_ns;
    logic              refuse;
    logic              issue_sec;

    assign va = vec_addr(tgt_secure ? vbase_s : vbase_ns,
                         (ADDR_W-2)'(exc_num));

    if (SEC_EXT) begin : g_sec
        excvec_sau #(.NREG(NREG)) u_sau (
            .addr  (va),
            .en    (sau_en),
            .nsc   (sau_nsc),
            .base  (sau_base),
            .limit (sau_limit),
            .is_ns (va_ns)
        );
        assign refuse    = !va_ns && !tgt_secure;
        assign issue_sec = !va_ns;
    end else begin : g_nosec
        assign va_ns     = !tgt_secure;
        assign refuse    = 1'b0;
        assign issue_sec = tgt_secure;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            req_q <= '0;
            exc_q <= '0;
            tgt_q <= 1'b0;
            fns_q <= 1'b0;
            vec_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    exc_q        <= exc_num;
                    tgt_q        <= tgt_secure;
                    fns_q        <= faults_ns;
                    req_q.addr   <= va;
                    req_q.secure <= issue_sec;
                    st           <= refuse ? ST_BAD : ST_REQ;
                end
                ST_REQ: if (bus_req_ready) begin
                    st <= ST_WAIT;
                end
                ST_WAIT: if (bus_rsp_valid) begin
                    if (bus_rsp_err) begin
                        st <= ST_BAD;
                    end else begin
                        vec_q <= bus_rsp_data;
                        st    <= ST_OK;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign bus_req_valid = (st == ST_REQ);
    assign bus_addr      = req_q.addr;
    assign bus_secure    = req_q.secure;
    assign bus_priv      = 1'b1;
    assign done          = (st == ST_OK) || (st == ST_BAD);
    assign fail          = (st == ST_BAD);
    assign vector        = vec_q;

    excvec_fault #(.EXC_W(EXC_W), .HF_NUM(HARDFAULT_NUM)) u_fault (
        .clk            (clk),
        .rst            (rst),
        .fail_evt       (fail),
        .exc_q          (exc_q),
        .tgt_q          (tgt_q),
        .fns_q          (fns_q),
        .hfsr_vecttbl   (hfsr_vecttbl),
        .hfsr_forced    (hfsr_forced),
        .hf_pend        (hf_pend),
        .hf_pend_secure (hf_pend_secure),
        .lockup         (lockup)
    );
endmodule

// File: rtl/excvec_fetch_chk.sv
module excvec_fetch_chk (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic        fail,
    input logic        hfsr_vecttbl,
    input logic        hfsr_forced,
    input logic        hf_pend,
    input logic        lockup,
    input logic        bus_req_valid,
    input logic        bus_req_ready,
    input logic [31:0] bus_addr,
    input logic        bus_secure,
    input logic        bus_priv,
    input logic        tgt_q
);
    assert_priv_R2: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> bus_priv);

    assert_no_secure_for_ns_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !tgt_q) |-> !bus_secure);

    assert_fail_only_done_R7: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_vecttbl_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        hfsr_vecttbl |=> hfsr_vecttbl);

    assert_forced_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        hfsr_forced |=> hfsr_forced);

    assert_pend_on_fail_R9: assert property (@(posedge clk) disable iff (rst)
        hf_pend |-> (done && fail));

    assert_lockup_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        lockup |=> lockup);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_req_ready) |=>
            (bus_req_valid && $stable(bus_addr) && $stable(bus_secure)));

    assert_no_req_while_done_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req_valid);
endmodule

bind excvec_fetch excvec_fetch_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .done          (done),
    .fail          (fail),
    .hfsr_vecttbl  (hfsr_vecttbl),
    .hfsr_forced   (hfsr_forced),
    .hf_pend       (hf_pend),
    .lockup        (lockup),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_addr      (bus_addr),
    .bus_secure    (bus_secure),
    .bus_priv      (bus_priv),
    .tgt_q         (tgt_q)
);

// File: tb/excvec_fetch_bench.sv
`timescale 1ns/1ps
module excvec_fetch_bench;
    localparam int NREG = 4;
    localparam int EXC_W = 9;
    localparam logic [31:0] BASE_S  = 32'h1000_0000;
    localparam logic [31:0] BASE_NS = 32'h2000_0000;

    typedef struct packed {
        logic [8:0] exc;
        logic       tgt;
        logic       fns;
        logic       err;
        logic       issue;
        logic       bsec;
        logic       fl;
        logic       hfsec;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t TBL [NROWS] = '{
        '{9'd16,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{9'd3,   1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{9'd40,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{9'd40,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{9'd100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{9'd2,   1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{9'd70,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{9'd20,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{9'd20,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{9'd16,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{9'd16,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{9'd5,   1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [EXC_W-1:0] exc_num = '0;
    logic tgt_secure = 1'b0;
    logic faults_ns = 1'b0;
    logic [NREG-1:0] sau_en;
    logic [NREG-1:0] sau_nsc;
    logic [NREG-1:0][26:0] sau_base;
    logic [NREG-1:0][26:0] sau_limit;
    logic done, fail, hfsr_vecttbl, hfsr_forced, hf_pend, hf_pend_secure, lockup;
    logic [31:0] vector;
    logic bus_req_valid, bus_secure, bus_priv;
    logic bus_req_ready = 1'b0;
    logic [31:0] bus_addr;
    logic bus_rsp_valid = 1'b0;
    logic [31:0] bus_rsp_data = '0;
    logic bus_rsp_err = 1'b0;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    logic g_issue, g_sec, g_priv, g_done, g_fail, g_pend, g_psec, g_lock;
    logic [31:0] g_addr, g_vec;
    int g_reqs;

    always #2.5 clk = ~clk;

    excvec_fetch #(.NREG(NREG), .EXC_W(EXC_W), .SEC_EXT(1'b1)) u_excvec_fetch (
        .clk(clk), .rst(rst), .start(start), .exc_num(exc_num),
        .tgt_secure(tgt_secure), .faults_ns(faults_ns),
        .vbase_s(BASE_S), .vbase_ns(BASE_NS),
        .sau_en(sau_en), .sau_nsc(sau_nsc), .sau_base(sau_base), .sau_limit(sau_limit),
        .done(done), .fail(fail), .vector(vector),
        .hfsr_vecttbl(hfsr_vecttbl), .hfsr_forced(hfsr_forced),
        .hf_pend(hf_pend), .hf_pend_secure(hf_pend_secure), .lockup(lockup),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_addr(bus_addr), .bus_secure(bus_secure), .bus_priv(bus_priv),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
        .bus_rsp_err(bus_rsp_err)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0001;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fetch(input logic [8:0] e, input logic t, input logic f,
                         input logic er, input int dly);
        int phase = 0;
        int cnt = 0;
        g_issue = 0; g_sec = 0; g_priv = 0; g_addr = '0; g_reqs = 0;
        g_done = 0; g_fail = 0; g_vec = '0; g_pend = 0; g_psec = 0; g_lock = 0;
        @(negedge clk);
        start = 1'b1; exc_num = e; tgt_secure = t; faults_ns = f;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (phase == 2) begin
                bus_rsp_valid = 1'b0;
                phase = 3;
            end else if (phase == 1) begin
                bus_req_ready = 1'b0;
                bus_rsp_valid = 1'b1;
                bus_rsp_data  = mem_word(g_addr);
                bus_rsp_err   = er;
                phase = 2;
            end else if (phase == 0 && bus_req_valid) begin
                if (cnt == 0) begin
                    g_issue = 1; g_sec = bus_secure; g_priv = bus_priv;
                    g_addr = bus_addr; g_reqs++;
                end else if (bus_addr !== g_addr) begin
                    g_reqs++;
                end
                if (cnt >= dly) begin
                    bus_req_ready = 1'b1;
                    phase = 1;
                end
                cnt++;
            end
            if (done) begin
                g_done = 1; g_fail = fail; g_vec = vector;
                g_pend = hf_pend; g_psec = hf_pend_secure; g_lock = lockup;
                break;
            end
            @(negedge clk);
        end
        bus_rsp_valid = 1'b0;
        bus_req_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        sau_en    = 4'b1111;
        sau_nsc   = 4'b0010;
        sau_base[0] = 27'h100_0000; sau_limit[0] = 27'h100_0007;
        sau_base[1] = 27'h080_0000; sau_limit[1] = 27'h080_0000;
        sau_base[2] = 27'h100_0004; sau_limit[2] = 27'h100_0007;
        sau_base[3] = 27'h080_0008; sau_limit[3] = 27'h080_000F;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 done",    32'(done), 0);
        chk("R12 fail",    32'(fail), 0);
        chk("R12 req",     32'(bus_req_valid), 0);
        chk("R12 pend",    32'(hf_pend), 0);
        chk("R12 lockup",  32'(lockup), 0);
        chk("R12 vecttbl", 32'(hfsr_vecttbl), 0);
        chk("R12 forced",  32'(hfsr_forced), 0);

        for (int r = 0; r < NROWS; r++) begin
            logic [31:0] ea;
            ea = (TBL[r].tgt ? BASE_S : BASE_NS) + {21'd0, TBL[r].exc, 2'b00};
            fetch(TBL[r].exc, TBL[r].tgt, TBL[r].fns, TBL[r].err, r % 3);
            chk("R7 done", 32'(g_done), 1);
            chk("R3/R4 issue", 32'(g_issue), 32'(TBL[r].issue));
            if (TBL[r].issue) begin
                chk("R1 addr", g_addr, ea);
                chk("R2 priv", 32'(g_priv), 1);
                chk("R3/R5 secure attr", 32'(g_sec), 32'(TBL[r].bsec));
                chk("R11 single request", 32'(g_reqs), 1);
            end
            chk("R4/R6 fail", 32'(g_fail), 32'(TBL[r].fl));
            if (!TBL[r].fl) chk("R7 vector", g_vec, mem_word(ea));
            chk("R9 pend", 32'(g_pend), 32'(TBL[r].fl));
            if (TBL[r].fl) chk("R9 pend secure", 32'(g_psec), 32'(TBL[r].hfsec));
            if (r == 1) begin
                chk("R8 no set on success", 32'(hfsr_vecttbl), 0);
            end
        end

        chk("R8 vecttbl set", 32'(hfsr_vecttbl), 1);
        chk("R8 forced set",  32'(hfsr_forced), 1);
        chk("R10 no lockup",  32'(lockup), 0);

        // R3 disabled region no longer makes an address non-secure
        sau_en[0] = 1'b0;
        fetch(9'd16, 1'b0, 1'b1, 1'b0, 0);
        chk("R3 disabled region issue", 32'(g_issue), 0);
        chk("R3 disabled region fail",  32'(g_fail), 1);

        // R10 HardFault fetch failure locks up
        fetch(9'd3, 1'b0, 1'b1, 1'b0, 0);
        chk("R10 fail",    32'(g_fail), 1);
        chk("R10 no pend", 32'(g_pend), 0);
        repeat (2) @(negedge clk);
        chk("R10 lockup held", 32'(lockup), 1);

        // R12 reset clears sticky state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 lockup cleared",  32'(lockup), 0);
        chk("R12 vecttbl cleared", 32'(hfsr_vecttbl), 0);
        chk("R12 forced cleared",  32'(hfsr_forced), 0);

        // R8 success after reset leaves status clear
        sau_en[0] = 1'b1;
        fetch(9'd16, 1'b0, 1'b1, 1'b0, 2);
        chk("R7 post-reset success", 32'(g_fail), 0);
        chk("R8 still clear", 32'(hfsr_vecttbl), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule